// File: doc/BRIEF.md
# Two-Way Instruction Pair Issue Control

This block sits between the fetch stage and the back end of a two-way in-order front end. Fetch hands it a bundle of two instructions together with the bundle address, the epoch the bundle was fetched under, and a flag that tells whether the fetch started on an 8-byte boundary. An aligned fetch supplies two usable instructions. An unaligned fetch supplies one. The block decides each cycle whether to send a pair, a single instruction, or nothing. It splits a pair over two cycles when the two instructions may not travel together. It discards bundles fetched down a path that a redirect has abandoned.

The block also owns the fetch address and the current epoch. On each accepted fetch the address moves on by 8 from a pair boundary, and by 4 otherwise. A redirect from the back end loads a new address and bumps the epoch. The back end reports, per bundle instruction, whether its hazard search blocks that instruction this cycle. The block consumes a bundle with a pop pulse once the bundle is fully issued or dropped. Fetch must hold a bundle steady until it is popped.

Instruction fields that the block decodes: bits [15:14] hold the opcode (00 add, 01 load, 10 store, 11 branch-if-zero). Bits [13:11], [10:8] and [7:5] hold register fields A, B and C. Bits [4:0] hold an immediate.

Top module: `ipi_dual_issue`

## Requirements
- R1: After reset the fetch address equals the RESET_PC parameter (0 by default) and the epoch is 0; with no bundle offered, neither slot is valid and there is no pop.
- R2: fetch_pair is high exactly when bit 2 of the fetch address is 0; an accepted fetch advances the address by 8 when fetch_pair is high and by 4 otherwise, in the next cycle.
- R3: A redirect loads redir_pc and increments the epoch (wrapping) in the next cycle, even when a fetch is accepted in the same cycle. In the redirect cycle nothing issues and nothing pops. The redirect also forgets any half-issued bundle.
- R4: A valid bundle whose epoch differs from the current epoch is popped in that cycle with neither slot valid.
- R5: An unaligned bundle issues its first instruction alone in slot 0 and pops, provided hz_first is low.
- R6: An aligned bundle issues as a pair when the second instruction is neither a load (01) nor a store (10), has no read-after-write dependence on the first, and both hazard inputs are low. Slot 0 then carries instr0 at bnd_pc, slot 1 carries instr1 at bnd_pc+4, and the bundle pops.
- R7: A read-after-write dependence exists when the first instruction is an add or a load (destination in field A) and the second reads that register. An add reads B and C, a load reads B, a store reads A and B, and a branch reads A.
- R8: An aligned bundle that cannot pair, or whose second instruction is blocked by hz_second, issues its first instruction alone without a pop. In a later cycle with hz_second low, the second instruction issues alone in slot 0 at bnd_pc+4 and the bundle pops.
- R9: While hz_first is high and the bundle has not been partly issued, nothing issues and the bundle stays unpopped.
- R10: Slot 1 is valid only together with slot 0, and it never carries a load or store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_take | input | 1 | Fetch accepted at the current fetch address |
| fetch_pc | output | PC_W | Current fetch address |
| fetch_pair | output | 1 | Current fetch address is on an 8-byte boundary |
| fetch_epoch | output | EPOCH_W | Current epoch, to tag fetched bundles |
| redir_valid | input | 1 | Back-end redirect request |
| redir_pc | input | PC_W | Redirect target address |
| bnd_valid | input | 1 | A bundle is offered |
| bnd_aligned | input | 1 | Bundle was fetched from a pair boundary |
| bnd_pc | input | PC_W | Address of the bundle's first instruction |
| bnd_epoch | input | EPOCH_W | Epoch the bundle was fetched under |
| bnd_instr0 | input | 16 | First instruction |
| bnd_instr1 | input | 16 | Second instruction (meaningful when aligned) |
| hz_first | input | 1 | Hazard search blocks the first instruction |
| hz_second | input | 1 | Hazard search blocks the second instruction |
| bnd_pop | output | 1 | Bundle consumed this cycle |
| iss0_valid | output | 1 | Slot 0 carries an instruction |
| iss0_instr | output | 16 | Slot 0 instruction |
| iss0_pc | output | PC_W | Slot 0 address |
| iss1_valid | output | 1 | Slot 1 carries an instruction |
| iss1_instr | output | 16 | Slot 1 instruction |
| iss1_pc | output | PC_W | Slot 1 address |

## Verification
The one state bit that matters is the half-issued flag. If it is wrong, the ports show it in the very next cycle that offers the bundle. A stuck-low flag re-issues the first instruction. A stuck-high flag skips it and sends the second at bnd_pc+4. A flag that survives a redirect makes the first fresh bundle after the redirect issue only its second half. The epoch and fetch address are visible directly one cycle after any take or redirect. A wrong pairing decision shows in the same cycle as a valid slot 1 that carries a memory operation or a dependent instruction, or as a missing slot 1 on a legal pair.

// File: rtl/ipi_pkg.sv
// Shared instruction field layout and decode helpers for the pair issue block.
// Assumes a 16-bit instruction: opcode, three register fields, immediate.
package ipi_pkg;

    localparam int OP_W    = 2;
    localparam int REG_W   = 3;
    localparam int IMM_W   = 5;
    localparam int INSTR_W = OP_W + 3 * REG_W + IMM_W;

    localparam int OP_LSB = INSTR_W - OP_W;
    localparam int FA_LSB = OP_LSB - REG_W;
    localparam int FB_LSB = FA_LSB - REG_W;
    localparam int FC_LSB = FB_LSB - REG_W;

    typedef enum logic [OP_W-1:0] {
        OPC_ADD   = 2'b00,
        OPC_LOAD  = 2'b01,
        OPC_STORE = 2'b10,
        OPC_BZ    = 2'b11
    } opc_e;

    typedef logic [INSTR_W-1:0] instr_t;
    typedef logic [REG_W-1:0]   reg_t;

    function automatic opc_e opc_of(input instr_t ins);
        return opc_e'(ins[OP_LSB +: OP_W]);
    endfunction

    function automatic reg_t fld_a(input instr_t ins);
        return ins[FA_LSB +: REG_W];
    endfunction

    function automatic reg_t fld_b(input instr_t ins);
        return ins[FB_LSB +: REG_W];
    endfunction

    function automatic reg_t fld_c(input instr_t ins);
        return ins[FC_LSB +: REG_W];
    endfunction

    function automatic logic is_mem(input instr_t ins);
        return (opc_of(ins) == OPC_LOAD) || (opc_of(ins) == OPC_STORE);
    endfunction

    function automatic logic has_dest(input instr_t ins);
        return (opc_of(ins) == OPC_ADD) || (opc_of(ins) == OPC_LOAD);
    endfunction

    // True when the instruction reads register r as a source operand.
    function automatic logic reads_reg(input instr_t ins, input reg_t r);
        logic hit;
        case (opc_of(ins))
            OPC_ADD:   hit = (fld_b(ins) == r) || (fld_c(ins) == r);
            OPC_LOAD:  hit = (fld_b(ins) == r);
            OPC_STORE: hit = (fld_a(ins) == r) || (fld_b(ins) == r);
            default:   hit = (fld_a(ins) == r);
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/ipi_fetch_pc.sv
// Fetch address and epoch register.
// Steps by 8 from a pair boundary and by 4 otherwise on each accepted fetch.
// A redirect overrides any fetch step: it loads the target and bumps the epoch.
module ipi_fetch_pc #(
    parameter int            PC_W     = 16,
    parameter int            EPOCH_W  = 2,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic               redir,
    input  logic [PC_W-1:0]    redir_pc,
    output logic [PC_W-1:0]    pc,
    output logic [EPOCH_W-1:0] epoch,
    output logic               pair
);

    localparam logic [PC_W-1:0] STEP_ONE  = PC_W'(4);
    localparam logic [PC_W-1:0] STEP_PAIR = PC_W'(8);

    logic [PC_W-1:0] step;

    // Pair boundary test and the matching step size.
    always_comb begin
        pair = (pc[2] == 1'b0);
        step = pair ? STEP_PAIR : STEP_ONE;
    end

    // Address and epoch update; redirect has priority over a fetch step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= RESET_PC;
            epoch <= '0;
        end else if (redir) begin
            pc    <= redir_pc;
            epoch <= epoch + EPOCH_W'(1);
        end else if (take) begin
            pc    <= pc + step;
        end
    end

    assert_redirect_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        redir |=> (pc == $past(redir_pc)) && (epoch == $past(epoch) + EPOCH_W'(1)));

    assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !redir) |=>
            (pc == $past(pc) + ($past(pc[2]) ? STEP_ONE : STEP_PAIR)) && $stable(epoch));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !redir) |=> $stable(pc) && $stable(epoch));

endmodule

// File: rtl/ipi_pair_check.sv
// Decides whether the two instructions of a bundle may issue in one cycle.
// A pair needs an aligned fetch, a non-memory second instruction,
// and no read of the first instruction's destination by the second.
module ipi_pair_check
    import ipi_pkg::*;
(
    input  instr_t first_i,
    input  instr_t second_i,
    input  logic   aligned,
    output logic   raw,
    output logic   pairable
);

    // Read-after-write test and slot legality for the second instruction.
    always_comb begin
        raw      = has_dest(first_i) && reads_reg(second_i, fld_a(first_i));
        pairable = aligned && !is_mem(second_i) && !raw;
    end

endmodule

// File: rtl/ipi_issue_ctrl.sv
// Per-cycle issue decision with a one-bit half-issued state.
// Assumes the offered bundle is held steady until it is popped.
// Outputs are combinational from the bundle, the hazards and the state bit.
module ipi_issue_ctrl
    import ipi_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redir,
    input  logic            bvalid,
    input  logic            stale,
    input  logic            aligned,
    input  logic            pairable,
    input  instr_t          b_i0,
    input  instr_t          b_i1,
    input  logic [PC_W-1:0] b_pc,
    input  logic            hz_first,
    input  logic            hz_second,
    output logic            pop,
    output logic            s0_valid,
    output instr_t          s0_instr,
    output logic [PC_W-1:0] s0_pc,
    output logic            s1_valid,
    output instr_t          s1_instr,
    output logic [PC_W-1:0] s1_pc
);

    localparam logic [PC_W-1:0] WORD = PC_W'(4);

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_DROP,
        ACT_PAIR,
        ACT_FIRST_ONLY,
        ACT_FIRST_SPLIT,
        ACT_SECOND
    } act_e;

    logic half_done;
    logic half_next;
    act_e act;

    // Choose this cycle's action.
    always_comb begin
        act = ACT_NONE;
        if (redir || !bvalid) begin
            act = ACT_NONE;
        end else if (stale) begin
            act = ACT_DROP;
        end else if (half_done) begin
            if (!hz_second) act = ACT_SECOND;
        end else if (!aligned) begin
            if (!hz_first) act = ACT_FIRST_ONLY;
        end else if (pairable && !hz_first && !hz_second) begin
            act = ACT_PAIR;
        end else if (!hz_first) begin
            act = ACT_FIRST_SPLIT;
        end
    end

    // Drive the slots and the pop pulse from the chosen action.
    always_comb begin
        s0_valid = (act == ACT_PAIR) || (act == ACT_FIRST_ONLY) ||
                   (act == ACT_FIRST_SPLIT) || (act == ACT_SECOND);
        s1_valid = (act == ACT_PAIR);
        pop      = (act == ACT_PAIR) || (act == ACT_FIRST_ONLY) ||
                   (act == ACT_SECOND) || (act == ACT_DROP);
        s0_instr = (act == ACT_SECOND) ? b_i1 : b_i0;
        s0_pc    = (act == ACT_SECOND) ? b_pc + WORD : b_pc;
        s1_instr = b_i1;
        s1_pc    = b_pc + WORD;
    end

    // Next value of the half-issued flag.
    always_comb begin
        half_next = half_done;
        if (redir)                        half_next = 1'b0;
        else if (act == ACT_FIRST_SPLIT)  half_next = 1'b1;
        else if (pop)                     half_next = 1'b0;
    end

    // Half-issued flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) half_done <= 1'b0;
        else        half_done <= half_next;
    end

    assert_slot1_with_slot0_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> s0_valid);

    assert_slot1_not_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> !is_mem(s1_instr));

    assert_pair_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> (s1_pc == s0_pc + WORD) && pop);

    assert_redirect_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        redir |-> !s0_valid && !pop);

    assert_stale_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && stale && !redir) |-> pop && !s0_valid);

    assert_split_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid && !pop) |=> (!s0_valid || (s0_pc == $past(s0_pc) + WORD)));

    assert_no_bundle_no_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bvalid |-> !s0_valid && !pop);

endmodule

// File: rtl/ipi_dual_issue.sv
// Top of the two-way pair issue control.
// Joins the fetch address/epoch register, the pairing check and the
// issue decision; a bundle is stale when its epoch differs from the current one.
module ipi_dual_issue
    import ipi_pkg::*;
#(
    parameter int              PC_W     = 16,
    parameter int              EPOCH_W  = 2,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_take,
    output logic [PC_W-1:0]    fetch_pc,
    output logic               fetch_pair,
    output logic [EPOCH_W-1:0] fetch_epoch,
    input  logic               redir_valid,
    input  logic [PC_W-1:0]    redir_pc,
    input  logic               bnd_valid,
    input  logic               bnd_aligned,
    input  logic [PC_W-1:0]    bnd_pc,
    input  logic [EPOCH_W-1:0] bnd_epoch,
    input  logic [15:0]        bnd_instr0,
    input  logic [15:0]        bnd_instr1,
    input  logic               hz_first,
    input  logic               hz_second,
    output logic               bnd_pop,
    output logic               iss0_valid,
    output logic [15:0]        iss0_instr,
    output logic [PC_W-1:0]    iss0_pc,
    output logic               iss1_valid,
    output logic [15:0]        iss1_instr,
    output logic [PC_W-1:0]    iss1_pc
);

    logic stale;
    logic raw;
    logic pairable;

    ipi_fetch_pc #(
        .PC_W     (PC_W),
        .EPOCH_W  (EPOCH_W),
        .RESET_PC (RESET_PC)
    ) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (fetch_take),
        .redir    (redir_valid),
        .redir_pc (redir_pc),
        .pc       (fetch_pc),
        .epoch    (fetch_epoch),
        .pair     (fetch_pair)
    );

    // Epoch comparison marks bundles from an abandoned path.
    always_comb begin
        stale = (bnd_epoch != fetch_epoch);
    end

    ipi_pair_check u_pair (
        .first_i  (bnd_instr0),
        .second_i (bnd_instr1),
        .aligned  (bnd_aligned),
        .raw      (raw),
        .pairable (pairable)
    );

    ipi_issue_ctrl #(
        .PC_W (PC_W)
    ) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .redir     (redir_valid),
        .bvalid    (bnd_valid),
        .stale     (stale),
        .aligned   (bnd_aligned),
        .pairable  (pairable),
        .b_i0      (bnd_instr0),
        .b_i1      (bnd_instr1),
        .b_pc      (bnd_pc),
        .hz_first  (hz_first),
        .hz_second (hz_second),
        .pop       (bnd_pop),
        .s0_valid  (iss0_valid),
        .s0_instr  (iss0_instr),
        .s0_pc     (iss0_pc),
        .s1_valid  (iss1_valid),
        .s1_instr  (iss1_instr),
        .s1_pc     (iss1_pc)
    );

    assert_dependent_never_paired_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_valid && raw) |-> !iss1_valid);

endmodule

// File: tb/tb_ipi_dual_issue.sv
module tb_ipi_dual_issue;

    localparam int PC_W = 16;
    localparam int EP_W = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fetch_take = 1'b0;
    logic [PC_W-1:0] fetch_pc;
    logic            fetch_pair;
    logic [EP_W-1:0] fetch_epoch;
    logic            redir_valid = 1'b0;
    logic [PC_W-1:0] redir_pc = '0;
    logic            bnd_valid = 1'b0;
    logic            bnd_aligned = 1'b0;
    logic [PC_W-1:0] bnd_pc = '0;
    logic [EP_W-1:0] bnd_epoch = '0;
    logic [15:0]     bnd_instr0 = '0;
    logic [15:0]     bnd_instr1 = '0;
    logic            hz_first = 1'b0;
    logic            hz_second = 1'b0;
    logic            bnd_pop;
    logic            iss0_valid;
    logic [15:0]     iss0_instr;
    logic [PC_W-1:0] iss0_pc;
    logic            iss1_valid;
    logic [15:0]     iss1_instr;
    logic [PC_W-1:0] iss1_pc;

    int n_chk = 0;
    int n_fail = 0;
    logic [EP_W-1:0] ep_m = '0;

    always #5 clk = ~clk;

    ipi_dual_issue dut (
        .clk(clk), .rst_n(rst_n), .fetch_take(fetch_take), .fetch_pc(fetch_pc),
        .fetch_pair(fetch_pair), .fetch_epoch(fetch_epoch), .redir_valid(redir_valid),
        .redir_pc(redir_pc), .bnd_valid(bnd_valid), .bnd_aligned(bnd_aligned),
        .bnd_pc(bnd_pc), .bnd_epoch(bnd_epoch), .bnd_instr0(bnd_instr0),
        .bnd_instr1(bnd_instr1), .hz_first(hz_first), .hz_second(hz_second),
        .bnd_pop(bnd_pop), .iss0_valid(iss0_valid), .iss0_instr(iss0_instr),
        .iss0_pc(iss0_pc), .iss1_valid(iss1_valid), .iss1_instr(iss1_instr),
        .iss1_pc(iss1_pc)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int op, input int a, input int b, input int c);
        return {2'(op), 3'(a), 3'(b), 3'(c), 5'd9};
    endfunction

    // Source-read rule from R7, written from the requirement text.
    function automatic logic m_reads(input int op, input logic [15:0] ins, input logic [2:0] r);
        case (op)
            0: return (ins[10:8] == r) || (ins[7:5] == r);
            1: return (ins[10:8] == r);
            2: return (ins[13:11] == r) || (ins[10:8] == r);
            default: return (ins[13:11] == r);
        endcase
    endfunction

    // Drive one bundle until the model says it is consumed, checking every cycle.
    task automatic run_bundle(input int op0, input int op1, input int dep,
                              input int al, input int hp);
        logic [15:0] i0, i1;
        logic [PC_W-1:0] pc;
        logic part_m, done, raw_m, pair_m;
        logic e0v, e1v, epop;
        logic [15:0] e0i;
        logic [PC_W-1:0] e0pc;
        string req;
        i0 = mk(op0, 1, 2, 3);
        case (dep)
            0: i1 = mk(op1, 4, 5, 6);
            1: i1 = mk(op1, 1, 1, 1);
            default: i1 = mk(op1, 4, 5, 1);
        endcase
        pc = al ? 16'h0100 : 16'h0104;
        raw_m  = (op0 <= 1) && m_reads(op1, i1, 3'd1);
        pair_m = (al != 0) && (op1 != 1) && (op1 != 2) && !raw_m;
        part_m = 1'b0;
        done   = 1'b0;
        for (int k = 0; k < 6 && !done; k++) begin
            @(negedge clk);
            bnd_valid   = 1'b1;
            bnd_aligned = (al != 0);
            bnd_pc      = pc;
            bnd_epoch   = ep_m;
            bnd_instr0  = i0;
            bnd_instr1  = i1;
            hz_first    = (k == 0) && hp[0];
            hz_second   = (k == 0) && hp[1];
            #2;
            e0v = 1'b0; e1v = 1'b0; epop = 1'b0; e0i = i0; e0pc = pc;
            if (part_m) begin
                req = "R8";
                if (!hz_second) begin
                    e0v = 1'b1; epop = 1'b1; e0i = i1; e0pc = pc + 16'd4;
                end
            end else if (al == 0) begin
                req = hz_first ? "R9" : "R5";
                if (!hz_first) begin e0v = 1'b1; epop = 1'b1; end
            end else if (pair_m && !hz_first && !hz_second) begin
                req = "R6";
                e0v = 1'b1; e1v = 1'b1; epop = 1'b1;
            end else if (!hz_first) begin
                req = raw_m ? "R7" : "R8";
                e0v = 1'b1;
            end else begin
                req = "R9";
            end
            check(req, "slot0 valid", 32'(iss0_valid), 32'(e0v));
            check(req, "slot1 valid R10", 32'(iss1_valid), 32'(e1v));
            check(req, "pop", 32'(bnd_pop), 32'(epop));
            if (e0v) begin
                check(req, "slot0 instr", 32'(iss0_instr), 32'(e0i));
                check(req, "slot0 pc", 32'(iss0_pc), 32'(e0pc));
            end
            if (e1v) begin
                check(req, "slot1 instr", 32'(iss1_instr), 32'(i1));
                check(req, "slot1 pc", 32'(iss1_pc), 32'(pc + 16'd4));
            end
            if (e0v && !epop) part_m = 1'b1;
            if (epop) done = 1'b1;
        end
        check("R8", "bundle consumed", 32'(done), 32'd1);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        check("R1", "fetch_pc", 32'(fetch_pc), 32'h0);
        check("R1", "epoch", 32'(fetch_epoch), 32'h0);
        check("R1", "slot0 valid", 32'(iss0_valid), 32'h0);
        check("R1", "pop", 32'(bnd_pop), 32'h0);
        check("R2", "pair flag at 0", 32'(fetch_pair), 32'h1);

        // R2: aligned step by 8
        @(negedge clk); fetch_take = 1'b1;
        @(negedge clk); fetch_take = 1'b0; #2;
        check("R2", "step 8", 32'(fetch_pc), 32'h8);

        // R3: redirect with a fresh bundle offered: quiet cycle
        @(negedge clk);
        redir_valid = 1'b1; redir_pc = 16'h0014;
        bnd_valid = 1'b1; bnd_aligned = 1'b1; bnd_epoch = 2'd0; bnd_pc = 16'h0008;
        bnd_instr0 = mk(0, 1, 2, 3); bnd_instr1 = mk(0, 4, 5, 6);
        #2;
        check("R3", "no issue on redirect", 32'(iss0_valid), 32'h0);
        check("R3", "no pop on redirect", 32'(bnd_pop), 32'h0);
        @(negedge clk); redir_valid = 1'b0; bnd_valid = 1'b0; #2;
        check("R3", "redirect pc", 32'(fetch_pc), 32'h14);
        check("R3", "epoch bump", 32'(fetch_epoch), 32'h1);
        check("R2", "pair flag at 0x14", 32'(fetch_pair), 32'h0);

        // R2: unaligned step by 4 then aligned step by 8
        @(negedge clk); fetch_take = 1'b1; #2;
        @(negedge clk); #2;
        check("R2", "step 4", 32'(fetch_pc), 32'h18);
        check("R2", "pair flag at 0x18", 32'(fetch_pair), 32'h1);
        @(negedge clk); fetch_take = 1'b0; #2;
        check("R2", "step 8 after 4", 32'(fetch_pc), 32'h20);

        // R3: three more redirects, one with a fetch take, epoch wraps to 0
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); redir_valid = 1'b1; redir_pc = 16'h0040; fetch_take = (i == 1);
        end
        @(negedge clk); redir_valid = 1'b0; fetch_take = 1'b0; #2;
        check("R3", "epoch wrap", 32'(fetch_epoch), 32'h0);
        check("R3", "redirect beats take", 32'(fetch_pc), 32'h40);
        ep_m = '0;

        // Sweep: opcode pairs, dependence variants, alignment, hazard patterns
        for (int op0 = 0; op0 < 4; op0++)
            for (int op1 = 0; op1 < 4; op1++)
                for (int dep = 0; dep < 3; dep++)
                    for (int al = 0; al < 2; al++)
                        for (int hp = 0; hp < 4; hp++)
                            run_bundle(op0, op1, dep, al, hp);

        // R4: stale bundle dropped
        @(negedge clk);
        bnd_valid = 1'b1; bnd_aligned = 1'b1; bnd_pc = 16'h0200; bnd_epoch = ep_m + 2'd1;
        bnd_instr0 = mk(0, 1, 2, 3); bnd_instr1 = mk(0, 4, 5, 6);
        hz_first = 1'b0; hz_second = 1'b0; #2;
        check("R4", "stale pop", 32'(bnd_pop), 32'h1);
        check("R4", "stale no issue", 32'(iss0_valid), 32'h0);

        // R3/R8: redirect clears a half-issued bundle
        @(negedge clk);
        bnd_epoch = ep_m; bnd_instr1 = mk(1, 4, 5, 6); #2;
        check("R8", "split first", 32'(iss0_valid), 32'h1);
        check("R8", "split no pop", 32'(bnd_pop), 32'h0);
        @(negedge clk); redir_valid = 1'b1; redir_pc = 16'h0300; #2;
        check("R3", "quiet during partial", 32'(iss0_valid), 32'h0);
        @(negedge clk); redir_valid = 1'b0; #2;
        check("R4", "half bundle dropped", 32'(bnd_pop), 32'h1);
        check("R4", "half bundle silent", 32'(iss0_valid), 32'h0);
        ep_m = ep_m + 2'd1;
        @(negedge clk);
        bnd_epoch = ep_m; bnd_pc = 16'h0300; bnd_instr1 = mk(0, 4, 5, 6); #2;
        check("R3", "fresh pair after clear", 32'(iss1_valid), 32'h1);
        check("R3", "fresh slot0 is first", 32'(iss0_instr), 32'(mk(0, 1, 2, 3)));
        @(negedge clk); bnd_valid = 1'b0; #2;
        check("R9", "idle no issue", 32'(iss0_valid), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule